// File: doc/BRIEF.md
# Banked SMBus Controller Register File

This block is the byte-wide register file of an SMBus/I2C controller. Software reaches it through single-byte reads and writes on a 5-bit offset. Most offsets map to one fixed register. The window from 0x10 to 0x1E shows one of two register sets, and bit 5 of the third control register picks which one. Each bit follows its own write rule. A bit may be plainly writable, cleared by writing a one, held at its old value, or read-only. One bit uses an inverted clear rule.

The protocol engine and the FIFO datapath sit outside this block. They act on it only through one-cycle set and clear event inputs and two line-level inputs. The block combines its flag bits into a single interrupt level, gated by a global enable, and mirrors that level into a read-only status bit. Writes to the start and stop command bits go out as one-cycle request pulses. Writing the module-enable bit as 0 clears the transfer state in one cycle.

Top module: `smb_bank_regs`

## Requirements
- R1: After reset, every offset reads 0, with these exceptions: 0x04 reads 0x10, 0x0E reads 0xC0 (bank 0, both line levels high), 0x1F reads 0x81, bank-0 offset 0x1A reads 0x07, bank-1 offset 0x14 reads 0x3F and bank-1 offset 0x1E reads 0x01.
- R2: Bit 5 of the register at 0x0E selects the window at 0x10–0x1E. Bank 0 holds eight address bytes (0x10–0x17) and plain bytes at 0x1A, 0x1B, 0x1C and 0x1E. Bank 1 holds plain bytes at 0x11 and 0x12. Common plain bytes are at 0x00, 0x08 and 0x0C. Every plain byte reads back exactly what was written to it.
- R3: In the status byte at 0x02, writing 1 clears bits 7, 5, 4, 3 and 2. Bits 6, 1 and 0 ignore writes. An engine set input wins over a software clear in the same cycle.
- R4: Bit 1 at 0x04 and bit 7 at 0x19 are cleared by writing 1. The other bits of 0x04 ignore writes.
- R5: Bits 7 and 6 at 0x0E always reflect the SCL and SDA level inputs, and writes to them are ignored. Writes to 0x18 and 0x1F have no effect.
- R6: A write to 0x06 stores bits 7, 6, 5, 3 and 2 and keeps the old values of bits 4, 1 and 0. Writing bit 0 or bit 1 as 1 produces a one-cycle start or stop request pulse on the next cycle.
- R7: irq is high only when bit 2 at 0x06 is set. It is then the OR of: status bit 5, status bit 4, status bit 6, status bit 2 gated by bit 6 at 0x06, busy-end (0x19 bit 7) gated by bit 3 at 0x06, RX threshold (bank 1 0x1C bit 6) gated by bank 1 0x1E bit 6, TX threshold (bank 1 0x1A bit 6) gated by bank 1 0x12 bit 6, and the FIFO flag (bank 1 0x10 bit 1) gated by bank 1 0x10 bit 3. Bit 7 at 0x18 reads the irq level.
- R8: Writing 0x0A with bit 0 clear zeroes 0x06, the status byte, 0x04, the busy-end bit, the FIFO flag and both threshold status bits. 0x0E keeps its value.
- R9: Bank 1 0x14: bits 6:0 are plain. Bit 7 is set by the timeout event and cleared by writing 1 to it. Writing 0 to bit 7 leaves it unchanged.
- R10: Bank 1 0x10: only bit 3 is writable. Writing 1 to bit 1 or to bit 6 clears the FIFO flag. Writing 1 to bit 6 also clears both threshold status bits.
- R11: Bank 1 0x1E bit 5, once written to 1, stays 1 when written 0, and its other bits are plain. The threshold bit 6 at bank 1 0x1A and at 0x1C is cleared by writing 1.
- R12: An access to an undefined offset (odd offsets below 0x10, and bank-1 offsets 0x13, 0x15–0x17, 0x1B, 0x1D) reads 0 and changes nothing. It raises err_strobe for one cycle, one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| st_set | input | 8 | Engine set events for the status byte |
| st_clr | input | 8 | Engine clear events for the status byte |
| cst_set | input | 8 | Engine set events for the bus-state byte |
| eob_set | input | 1 | Busy-end event |
| fifo_flag_set | input | 1 | FIFO empty/full event |
| tx_thr_set | input | 1 | TX threshold event |
| rx_thr_set | input | 1 | RX threshold event |
| tmo_set | input | 1 | Timeout event |
| scl_lvl | input | 1 | Sampled SCL level |
| sda_lvl | input | 1 | Sampled SDA level |
| irq | output | 1 | Interrupt level |
| start_req | output | 1 | One-cycle start request |
| stop_req | output | 1 | One-cycle stop request |
| err_strobe | output | 1 | One-cycle undefined-access flag |

## Verification
Every offset is read in both banks after reset and compared with a computed reset map. Every undefined offset is written with all ones and then read back, which separates a decode hole from an aliased register. Plain registers are filled with a pattern computed from offset and bank, so an address mix-up between banks shows up. For the interrupt, each of the eight source terms is swept across both states of its own enable and both states of the global enable. That sweep tells apart the gated terms from the unconditional ones and catches a wrong gating bit.

// File: rtl/smb_bank_regs.sv
module smb_bank_regs #(
  parameter logic [7:0] VERSION = 8'h81
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] st_set,
  input  logic [7:0] st_clr,
  input  logic [7:0] cst_set,
  input  logic       eob_set,
  input  logic       fifo_flag_set,
  input  logic       tx_thr_set,
  input  logic       rx_thr_set,
  input  logic       tmo_set,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  output logic       irq,
  output logic       start_req,
  output logic       stop_req,
  output logic       err_strobe
);
  localparam logic [4:0] O_DATA = 5'h00, O_STAT = 5'h02, O_BUS = 5'h04, O_CMD = 5'h06;
  localparam logic [4:0] O_SA0 = 5'h08, O_ENA = 5'h0A, O_SA1 = 5'h0C, O_CFG = 5'h0E;
  localparam logic [4:0] O_IRQS = 5'h18, O_EOB = 5'h19, O_VER = 5'h1F;
  localparam logic [4:0] O_B0D = 5'h1A, O_B0E = 5'h1B, O_SCLL = 5'h1C, O_FCTL = 5'h1D, O_SCLH = 5'h1E;
  localparam logic [4:0] O_FCS = 5'h10, O_FAIR = 5'h11, O_TXC = 5'h12, O_TMO = 5'h14;
  localparam logic [4:0] O_TXS = 5'h1A, O_RXS = 5'h1C, O_RXC = 5'h1E;
  localparam logic [7:0] STAT_W1C = 8'hBC;
  localparam int NXA = 8;

  logic [7:0] data_q, stat_q, bus_q, cmd_q, sa0_q, ena_q, sa1_q;
  logic [5:0] cfg_q;
  logic       eob_q, txthr_q, rxthr_q;
  logic [7:0] xa_q [NXA];
  logic [7:0] b0d_q, b0e_q, scll_q, sclh_q, fctl_q;
  logic [7:0] fcs_q, fair_q, txc_q, tmo_q, rxc_q;
  logic       undef;

  wire bank = cfg_q[5];
  wire b0 = !bank;
  wire w_data = wr_en && addr == O_DATA;
  wire w_stat = wr_en && addr == O_STAT;
  wire w_bus  = wr_en && addr == O_BUS;
  wire w_cmd  = wr_en && addr == O_CMD;
  wire w_sa0  = wr_en && addr == O_SA0;
  wire w_ena  = wr_en && addr == O_ENA;
  wire w_sa1  = wr_en && addr == O_SA1;
  wire w_cfg  = wr_en && addr == O_CFG;
  wire w_eob  = wr_en && addr == O_EOB;
  wire w_xa   = wr_en && b0 && addr[4:3] == 2'b10;
  wire w_b0d  = wr_en && b0 && addr == O_B0D;
  wire w_b0e  = wr_en && b0 && addr == O_B0E;
  wire w_scll = wr_en && b0 && addr == O_SCLL;
  wire w_fctl = wr_en && b0 && addr == O_FCTL;
  wire w_sclh = wr_en && b0 && addr == O_SCLH;
  wire w_fcs  = wr_en && bank && addr == O_FCS;
  wire w_fair = wr_en && bank && addr == O_FAIR;
  wire w_txc  = wr_en && bank && addr == O_TXC;
  wire w_tmo  = wr_en && bank && addr == O_TMO;
  wire w_txs  = wr_en && bank && addr == O_TXS;
  wire w_rxs  = wr_en && bank && addr == O_RXS;
  wire w_rxc  = wr_en && bank && addr == O_RXC;
  wire fifo_clr = w_fcs && wdata[6];
  wire disable_wr = w_ena && !wdata[0];

  assign irq = cmd_q[2] && ((cmd_q[6] && stat_q[2]) || stat_q[5] || stat_q[4] || stat_q[6] ||
                            (cmd_q[3] && eob_q) || (rxc_q[6] && rxthr_q) ||
                            (txc_q[6] && txthr_q) || (fcs_q[3] && fcs_q[1]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0; stat_q <= '0; bus_q <= 8'h10; cmd_q <= '0; sa0_q <= '0;
      ena_q <= '0; sa1_q <= '0; cfg_q <= '0; eob_q <= 1'b0;
      for (int i = 0; i < NXA; i++) xa_q[i] <= '0;
      b0d_q <= 8'h07; b0e_q <= '0; scll_q <= '0; sclh_q <= '0; fctl_q <= '0;
      fcs_q <= '0; fair_q <= '0; txc_q <= '0; tmo_q <= 8'h3F; rxc_q <= 8'h01;
      txthr_q <= 1'b0; rxthr_q <= 1'b0;
      start_req <= 1'b0; stop_req <= 1'b0; err_strobe <= 1'b0;
    end else begin
      if (w_data) data_q <= wdata;
      stat_q <= (stat_q & ~(w_stat ? (wdata & STAT_W1C) : 8'h00) & ~st_clr) | st_set;
      bus_q  <= (bus_q & ~(w_bus ? (wdata & 8'h02) : 8'h00)) | cst_set;
      if (w_cmd) cmd_q <= (wdata & 8'hEC) | (cmd_q & 8'h13);
      if (w_sa0) sa0_q <= wdata;
      if (w_ena) ena_q <= wdata;
      if (w_sa1) sa1_q <= wdata;
      if (w_cfg) cfg_q <= wdata[5:0];
      eob_q <= (eob_q && !(w_eob && wdata[7])) || eob_set;
      if (w_xa) xa_q[addr[2:0]] <= wdata;
      if (w_b0d) b0d_q <= wdata;
      if (w_b0e) b0e_q <= wdata;
      if (w_scll) scll_q <= wdata;
      if (w_sclh) sclh_q <= wdata;
      if (w_fctl) fctl_q <= {wdata[7:2], fctl_q[1] & ~wdata[1], fctl_q[0]};
      fcs_q <= {fcs_q[7] & ~(w_fcs & wdata[7]), 3'b000, w_fcs ? wdata[3] : fcs_q[3], 1'b0,
                (fcs_q[1] & ~(w_fcs & (wdata[1] | wdata[6]))) | fifo_flag_set, 1'b0};
      if (w_fair) fair_q <= wdata;
      if (w_txc) txc_q <= wdata;
      tmo_q <= {(w_tmo ? (~wdata[7] & tmo_q[7]) : tmo_q[7]) | tmo_set,
                w_tmo ? wdata[6:0] : tmo_q[6:0]};
      if (w_rxc) rxc_q <= {wdata[7:6], wdata[5] | rxc_q[5], wdata[4:0]};
      txthr_q <= (txthr_q && !(w_txs && wdata[6]) && !fifo_clr) || tx_thr_set;
      rxthr_q <= (rxthr_q && !(w_rxs && wdata[6]) && !fifo_clr) || rx_thr_set;
      if (disable_wr) begin
        cmd_q <= '0; stat_q <= '0; bus_q <= '0; eob_q <= 1'b0;
        fcs_q[1] <= 1'b0; txthr_q <= 1'b0; rxthr_q <= 1'b0;
      end
      start_req  <= w_cmd && wdata[0];
      stop_req   <= w_cmd && wdata[1];
      err_strobe <= (wr_en || rd_en) && undef;
    end
  end

  always_comb begin
    rdata = '0;
    undef = 1'b0;
    case (addr)
      O_DATA: rdata = data_q;
      O_STAT: rdata = stat_q;
      O_BUS:  rdata = bus_q;
      O_CMD:  rdata = cmd_q;
      O_SA0:  rdata = sa0_q;
      O_ENA:  rdata = ena_q;
      O_SA1:  rdata = sa1_q;
      O_CFG:  rdata = {scl_lvl, sda_lvl, cfg_q};
      O_IRQS: rdata = {irq, 7'b0};
      O_EOB:  rdata = {eob_q, 7'b0};
      O_VER:  rdata = VERSION;
      default: begin
        if (addr[4] == 1'b0) undef = 1'b1;
        else if (!bank) begin
          if (addr[3] == 1'b0) rdata = xa_q[addr[2:0]];
          else case (addr)
            O_B0D:  rdata = b0d_q;
            O_B0E:  rdata = b0e_q;
            O_SCLL: rdata = scll_q;
            O_FCTL: rdata = fctl_q;
            O_SCLH: rdata = sclh_q;
            default: undef = 1'b1;
          endcase
        end else begin
          case (addr)
            O_FCS:  rdata = fcs_q;
            O_FAIR: rdata = fair_q;
            O_TXC:  rdata = txc_q;
            O_TMO:  rdata = tmo_q;
            O_TXS:  rdata = {1'b0, txthr_q, 6'b0};
            O_RXS:  rdata = {1'b0, rxthr_q, 6'b0};
            O_RXC:  rdata = rxc_q;
            default: undef = 1'b1;
          endcase
        end
      end
    endcase
  end

  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && wdata[5] && !st_set[5]) |=> !stat_q[5]); // R3
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    w_cmd |=> (cmd_q[4] == $past(cmd_q[4]) && cmd_q[0] == $past(cmd_q[0]))); // R6
  AST_START_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(wr_en && addr == O_CMD && wdata[0])); // R6
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmd && !wdata[2]) |=> !irq); // R7
  AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    disable_wr |=> (cmd_q == 8'h00 && stat_q == 8'h00 && bus_q == 8'h00 && !eob_q)); // R8
  AST_TMO_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (w_tmo && wdata[7] && !tmo_set) |=> !tmo_q[7]); // R9
  AST_RXC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (w_rxc && rxc_q[5]) |=> rxc_q[5]); // R11
endmodule

// File: tb/smb_bank_regs_tb.sv
module smb_bank_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] st_set = '0, st_clr = '0, cst_set = '0;
  logic eob_set = 0, fifo_flag_set = 0, tx_thr_set = 0, rx_thr_set = 0, tmo_set = 0;
  logic scl_lvl = 1'b1, sda_lvl = 1'b1;
  logic irq, start_req, stop_req, err_strobe;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  smb_bank_regs dut_i (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .st_set, .st_clr,
    .cst_set, .eob_set, .fifo_flag_set, .tx_thr_set, .rx_thr_set, .tmo_set, .scl_lvl, .sda_lvl,
    .irq, .start_req, .stop_req, .err_strobe);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_src(input int t);
    @(negedge clk);
    case (t)
      0: st_set = 8'h04; 1: st_set = 8'h20; 2: st_set = 8'h10; 3: st_set = 8'h40;
      4: eob_set = 1; 5: rx_thr_set = 1; 6: tx_thr_set = 1; default: fifo_flag_set = 1;
    endcase
    @(negedge clk);
    st_set = '0; eob_set = 0; rx_thr_set = 0; tx_thr_set = 0; fifo_flag_set = 0;
  endtask

  function automatic logic [7:0] reset_val(input bit b, input int o);
    case (o)
      'h04: return 8'h10;
      'h0E: return b ? 8'hE0 : 8'hC0;
      'h1F: return 8'h81;
      'h1A: return b ? 8'h00 : 8'h07;
      'h14: return b ? 8'h3F : 8'h00;
      'h1E: return b ? 8'h01 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit is_def(input bit b, input int o);
    if (o < 'h10) return (o % 2) == 0;
    if (o == 'h18 || o == 'h19 || o == 'h1F) return 1;
    if (!b) return 1;
    return o == 'h10 || o == 'h11 || o == 'h12 || o == 'h14 || o == 'h1A || o == 'h1C || o == 'h1E;
  endfunction

  function automatic bit is_plain(input bit b, input int o);
    if (o == 'h00 || o == 'h08 || o == 'h0C) return 1;
    if (!b) return (o >= 'h10 && o <= 'h17) || o == 'h1A || o == 'h1B || o == 'h1C || o == 'h1E;
    return o == 'h11 || o == 'h12;
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset map, both banks
    for (int b = 0; b < 2; b++) begin
      if (b == 1) wr(5'h0E, 8'h20);
      for (int o = 0; o < 32; o++) begin
        rd(o[4:0], v);
        chk($sformatf("R1 reset b%0d o%0h", b, o), v, reset_val(b[0], o));
      end
    end
    // R12 undefined offsets
    for (int b = 0; b < 2; b++) begin
      wr(5'h0E, b[0] ? 8'h20 : 8'h00);
      for (int o = 0; o < 32; o++) begin
        if (!is_def(b[0], o)) begin
          @(negedge clk); addr = o[4:0]; wdata = 8'hFF; wr_en = 1'b1;
          @(negedge clk); wr_en = 1'b0;
          chk($sformatf("R12 err b%0d o%0h", b, o), {7'b0, err_strobe}, 8'h01);
          @(negedge clk);
          chk($sformatf("R12 err drop o%0h", o), {7'b0, err_strobe}, 8'h00);
          rd(o[4:0], v);
          chk($sformatf("R12 read0 b%0d o%0h", b, o), v, 8'h00);
        end
      end
    end
    // R2 plain registers with bank-dependent pattern
    for (int b = 0; b < 2; b++) begin
      wr(5'h0E, b[0] ? 8'h20 : 8'h00);
      for (int o = 0; o < 32; o++)
        if (is_plain(b[0], o)) wr(o[4:0], 8'((o * 7 + b * 8'h55) ^ 8'hA5));
    end
    for (int b = 0; b < 2; b++) begin
      wr(5'h0E, b[0] ? 8'h20 : 8'h00);
      for (int o = 0; o < 32; o++)
        if (is_plain(b[0], o)) begin
          rd(o[4:0], v);
          chk($sformatf("R2 plain b%0d o%0h", b, o), v, 8'((o * 7 + (o < 'h10 ? 1 : b) * 8'h55) ^ 8'hA5));
        end
    end
    // R3 status rules
    @(negedge clk); st_set = 8'hFF; @(negedge clk); st_set = 8'h00;
    wr(5'h02, 8'hBC); rd(5'h02, v); chk("R3 w1c", v, 8'h43);
    wr(5'h02, 8'h43); rd(5'h02, v); chk("R3 ro bits", v, 8'h43);
    @(negedge clk); st_clr = 8'h43; @(negedge clk); st_clr = 8'h00;
    @(negedge clk); addr = 5'h02; wdata = 8'h20; wr_en = 1'b1; st_set = 8'h20;
    @(negedge clk); wr_en = 1'b0; st_set = 8'h00;
    rd(5'h02, v); chk("R3 set wins", v, 8'h20);
    // R4
    @(negedge clk); cst_set = 8'h06; @(negedge clk); cst_set = 8'h00;
    wr(5'h04, 8'h06); rd(5'h04, v); chk("R4 bus w1c", v, 8'h14);
    @(negedge clk); eob_set = 1; @(negedge clk); eob_set = 0;
    rd(5'h19, v); chk("R4 eob set", v, 8'h80);
    wr(5'h19, 8'h80); rd(5'h19, v); chk("R4 eob w1c", v, 8'h00);
    // R5
    scl_lvl = 1'b1; sda_lvl = 1'b0;
    wr(5'h0E, 8'hFF); rd(5'h0E, v); chk("R5 line bits", v, 8'hBF);
    sda_lvl = 1'b1;
    wr(5'h06, 8'h00);
    wr(5'h18, 8'hFF); rd(5'h18, v); chk("R5 irq stat ro", v, 8'h00);
    wr(5'h1F, 8'h00); rd(5'h1F, v); chk("R5 version ro", v, 8'h81);
    // R6
    @(negedge clk); addr = 5'h06; wdata = 8'hFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R6 pulses", {6'b0, stop_req, start_req}, 8'h03);
    @(negedge clk);
    chk("R6 pulse width", {6'b0, stop_req, start_req}, 8'h00);
    rd(5'h06, v); chk("R6 hold bits", v, 8'hEC);
    wr(5'h06, 8'h00); rd(5'h06, v); chk("R6 clear", v, 8'h00);
    // R9 R10 R11 in bank 1
    wr(5'h0E, 8'h20);
    @(negedge clk); tmo_set = 1; @(negedge clk); tmo_set = 0;
    rd(5'h14, v); chk("R9 tmo set", v, 8'hBF);
    wr(5'h14, 8'h05); rd(5'h14, v); chk("R9 write0 keeps", v, 8'h85);
    wr(5'h14, 8'h80); rd(5'h14, v); chk("R9 write1 clears", v, 8'h00);
    wr(5'h14, 8'h80); rd(5'h14, v); chk("R9 stays clear", v, 8'h00);
    @(negedge clk); fifo_flag_set = 1; @(negedge clk); fifo_flag_set = 0;
    rd(5'h10, v); chk("R10 flag set", v, 8'h02);
    wr(5'h10, 8'hBF); rd(5'h10, v); chk("R10 ie and w1c", v, 8'h08);
    @(negedge clk); fifo_flag_set = 1; tx_thr_set = 1; rx_thr_set = 1;
    @(negedge clk); fifo_flag_set = 0; tx_thr_set = 0; rx_thr_set = 0;
    wr(5'h10, 8'h40);
    rd(5'h10, v); chk("R10 clr fifo cts", v, 8'h00);
    rd(5'h1A, v); chk("R10 clr txs", v, 8'h00);
    rd(5'h1C, v); chk("R10 clr rxs", v, 8'h00);
    wr(5'h1E, 8'h20); wr(5'h1E, 8'h00); rd(5'h1E, v); chk("R11 sticky", v, 8'h20);
    wr(5'h1E, 8'h41); rd(5'h1E, v); chk("R11 plain", v, 8'h61);
    @(negedge clk); tx_thr_set = 1; rx_thr_set = 1; @(negedge clk); tx_thr_set = 0; rx_thr_set = 0;
    rd(5'h1A, v); chk("R11 tx thr", v, 8'h40);
    wr(5'h1A, 8'h40); rd(5'h1A, v); chk("R11 tx w1c", v, 8'h00);
    wr(5'h1C, 8'h40); rd(5'h1C, v); chk("R11 rx w1c", v, 8'h00);
    // R8 disable
    @(negedge clk); st_set = 8'h7F; cst_set = 8'h13; eob_set = 1; fifo_flag_set = 1;
    tx_thr_set = 1; rx_thr_set = 1;
    @(negedge clk); st_set = 0; cst_set = 0; eob_set = 0; fifo_flag_set = 0; tx_thr_set = 0; rx_thr_set = 0;
    wr(5'h06, 8'h44);
    wr(5'h0A, 8'h00);
    rd(5'h06, v); chk("R8 cmd", v, 8'h00);
    rd(5'h02, v); chk("R8 stat", v, 8'h00);
    rd(5'h04, v); chk("R8 bus", v, 8'h00);
    rd(5'h19, v); chk("R8 eob", v, 8'h00);
    rd(5'h10, v); chk("R8 fifo flag", v, 8'h00);
    rd(5'h1A, v); chk("R8 txs", v, 8'h00);
    rd(5'h1C, v); chk("R8 rxs", v, 8'h00);
    rd(5'h0E, v); chk("R8 cfg kept", v, 8'hE0);
    // R7 interrupt sweep
    for (int t = 0; t < 8; t++)
      for (int ie = 0; ie < 2; ie++)
        for (int en = 0; en < 2; en++) begin
          logic exp_irq;
          wr(5'h0A, 8'h00); wr(5'h0A, 8'h01);
          wr(5'h1E, (t == 5 && ie == 1) ? 8'h40 : 8'h00);
          wr(5'h12, (t == 6 && ie == 1) ? 8'h40 : 8'h00);
          wr(5'h10, (t == 7 && ie == 1) ? 8'h08 : 8'h00);
          wr(5'h06, 8'((en << 2) | ((t == 0 && ie == 1) ? 8'h40 : 8'h00) | ((t == 4 && ie == 1) ? 8'h08 : 8'h00)));
          pulse_src(t);
          exp_irq = (en == 1) && (t == 1 || t == 2 || t == 3 || ie == 1);
          chk($sformatf("R7 irq t%0d ie%0d en%0d", t, ie, en), {7'b0, irq}, {7'b0, exp_irq});
          rd(5'h18, v);
          chk($sformatf("R7 mirror t%0d ie%0d en%0d", t, ie, en), v, {exp_irq, 7'b0});
        end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule